// File: doc/BRIEF.md
# Horizontal Sync Regenerator with Half-Line Mask

This block takes a positive-going composite sync stream and produces a clean horizontal sync train with exactly one pulse per scan line. During the frame interval, the composite stream carries equalizing and broad pulses at twice the line rate. The block drops every pulse that arrives too soon after the last one it accepted, so a display that expects one sync per line sees an unbroken train.

The input first passes through a two-flop synchronizer. Each rising edge then starts a retriggerable stretcher one-shot. The leading edge of the stretched pulse fires a non-retriggerable output one-shot, but only while the mask is open. The rising edge of the output pulse starts a retriggerable mask one-shot, which keeps the mask closed for a fixed hold-off window. All three pulse widths are parameters counted in clock cycles. The mask state is brought out on a port so that it can be observed.

Top module: `hsync_regen`

## Requirements
- R1: After reset, `hsync_out` is low and `mask_open` is high, so the first incoming sync rise is accepted.
- R2: An accepted sync rise drives `hsync_out` high starting 3 clock cycles after the first rising clock edge that samples `sync_in` high.
- R3: Each output pulse stays high for exactly OUT_CYC clock cycles.
- R4: `mask_open` goes low one cycle after `hsync_out` rises and stays low for exactly MASK_CYC cycles.
- R5: A sync rise is accepted only if it comes at least MASK_CYC+2 cycles after the previous accepted rise. A rise that comes earlier is dropped, even if the mask reopens while that rise's stretched pulse is still high.
- R6: Only the leading edge of the stretched pulse can fire the output, and the stretched pulse lasts STRETCH_CYC cycles from its last trigger.
- R7: The stretcher is retriggerable. A sync rise that comes no more than STRETCH_CYC cycles after the previous sync rise restarts the stretched pulse without creating a new leading edge. A continuous chain of such rises therefore produces only one output pulse, however long the chain lasts.
- R8: For a line-rate sequence with half-line equalizing and broad pulses in the frame interval, the output pulses stay exactly one line period apart throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Positive composite sync, asynchronous |
| hsync_out | output | 1 | Regenerated horizontal sync, active high |
| mask_open | output | 1 | High while new sync rises may fire the output |

## Verification
The output rises 3 cycles after the first clock edge that samples the input high. The mask falls 4 cycles after that edge and reopens MASK_CYC cycles later. The bench keeps a cycle-indexed model of the last two accepted rises. It applies the stretcher-merge rule and the hold-off rule to each driven rise, and from these derives the expected level of both outputs for every cycle. Both outputs are compared on the falling clock edge, half a cycle after the registers settle. Pulse-count checks are made only after an idle tail longer than the output and mask windows, so that no pulse is still pending when it is counted.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

  // Counter width able to hold the value w.
  function automatic int unsigned cnt_width(input int unsigned w);
    return (w < 2) ? 1 : $clog2(w + 1);
  endfunction

  // Cycles from the first edge sampling the input high to the output rise.
  function automatic int unsigned fire_latency(input int unsigned stages);
    return stages + 1;
  endfunction

  // Smallest spacing of accepted rises, in cycles.
  function automatic int unsigned min_accept_gap(input int unsigned mask_w);
    return mask_w + 2;
  endfunction

endpackage

// File: rtl/hsr_sync.sv
module hsr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/hsr_rise.sv
module hsr_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise
);
  logic d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) d_q <= 1'b0;
    else        d_q <= d;
  end

  assign rise = d & ~d_q;
endmodule

// File: rtl/hsr_oneshot.sv
module hsr_oneshot #(
  parameter int unsigned WIDTH  = 8,
  parameter bit          RETRIG = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int unsigned    CW   = hsr_pkg::cnt_width(WIDTH);
  localparam logic [CW-1:0]  LOAD = CW'(WIDTH);

  logic [CW-1:0] cnt;
  logic          load;

  generate
    if (RETRIG) begin : g_retrig
      assign load = trig;
    end else begin : g_single
      assign load = trig && (cnt == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign pulse = (cnt != '0);
endmodule

// File: rtl/hsync_regen.sv
module hsync_regen #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STRETCH_CYC = 400,
  parameter int unsigned OUT_CYC     = 945,
  parameter int unsigned MASK_CYC    = 1750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic hsync_out,
  output logic mask_open
);
  logic sync_q;
  logic in_rise;
  logic stretch_q;
  logic stretch_rise;
  logic fire;
  logic hsync_q;
  logic hsync_rise;
  logic mask_q;

  hsr_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(sync_in), .q(sync_q)
  );

  hsr_rise i_in_edge (
    .clk(clk), .rst_n(rst_n), .d(sync_q), .rise(in_rise)
  );

  hsr_oneshot #(.WIDTH(STRETCH_CYC), .RETRIG(1'b1)) i_stretch (
    .clk(clk), .rst_n(rst_n), .trig(in_rise), .pulse(stretch_q)
  );

  hsr_rise i_st_edge (
    .clk(clk), .rst_n(rst_n), .d(stretch_q), .rise(stretch_rise)
  );

  // Only the leading edge of the stretched pulse, seen through an open mask, fires.
  assign fire = stretch_rise & ~mask_q;

  hsr_oneshot #(.WIDTH(OUT_CYC), .RETRIG(1'b0)) i_out (
    .clk(clk), .rst_n(rst_n), .trig(fire), .pulse(hsync_q)
  );

  hsr_rise i_out_edge (
    .clk(clk), .rst_n(rst_n), .d(hsync_q), .rise(hsync_rise)
  );

  hsr_oneshot #(.WIDTH(MASK_CYC), .RETRIG(1'b1)) i_mask (
    .clk(clk), .rst_n(rst_n), .trig(hsync_rise), .pulse(mask_q)
  );

  assign hsync_out = hsync_q;
  assign mask_open = ~mask_q;
endmodule

// File: rtl/hsync_regen_chk.sv
module hsync_regen_chk #(
  parameter int unsigned OUT_CYC  = 945,
  parameter int unsigned MASK_CYC = 1750
) (
  input logic clk,
  input logic rst_n,
  input logic hsync_out,
  input logic mask_open,
  input logic in_rise
);
  logic [31:0] hi_cnt;
  logic [31:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= hsync_out ? hi_cnt + 1 : '0;
      lo_cnt <= mask_open ? '0 : lo_cnt + 1;
    end
  end

  // R2
  fire_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_out) |-> $past(in_rise, 2));

  // R3
  out_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync_out) |-> (hi_cnt == OUT_CYC));

  // R4
  mask_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_out) |=> !mask_open);

  // R4
  mask_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mask_open) |-> (lo_cnt == MASK_CYC));

  // R5
  fire_when_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_out) |-> mask_open);
endmodule

bind hsync_regen hsync_regen_chk #(.OUT_CYC(OUT_CYC), .MASK_CYC(MASK_CYC)) i_chk (
  .clk(clk), .rst_n(rst_n), .hsync_out(hsync_out),
  .mask_open(mask_open), .in_rise(in_rise)
);

// File: tb/test_hsync_regen.sv
module test_hsync_regen;
  localparam int LINE = 640;
  localparam int HALF = 320;
  localparam int SW   = 80;
  localparam int OW   = 189;
  localparam int MW   = 350;
  localparam int LAT  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b0;
  logic hsync_out;
  logic mask_open;

  always #10 clk = ~clk;

  hsync_regen #(.SYNC_STAGES(2), .STRETCH_CYC(SW), .OUT_CYC(OW), .MASK_CYC(MW)) i_hsync_regen (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in),
    .hsync_out(hsync_out), .mask_open(mask_open)
  );

  int  n_tests = 0;
  int  n_fail  = 0;
  int  cyc     = 0;
  bit  mon_en  = 1'b0;
  bit  done    = 1'b0;

  // reference model state
  bit  in_valid = 1'b0, acc_valid = 1'b0, prev_valid = 1'b0;
  int  last_in = 0, la = 0, la_prev = 0, n_acc = 0;

  // observation state
  bit  h_last = 1'b0, pal_on = 1'b0, have_rise = 1'b0;
  int  n_rise = 0, last_rise = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic bit in_win(input bit v, input int base, input int off, input int len, input int n);
    return v && (n >= base + off) && (n < base + off + len);
  endfunction

  // Model of one driven rise, first sampled at edge e.
  task automatic note_rise(input int e);
    bit fresh;
    fresh = !in_valid || (e - last_in >= SW + 1);
    last_in = e;
    in_valid = 1'b1;
    if (fresh && (!acc_valid || (e - la >= MW + 2))) begin
      la_prev = la;
      prev_valid = acc_valid;
      la = e;
      acc_valid = 1'b1;
      n_acc++;
    end
  endtask

  task automatic send(input int hi, input int period);
    @(negedge clk);
    sync_in = 1'b1;
    note_rise(cyc + 1);
    repeat (hi) @(negedge clk);
    sync_in = 1'b0;
    repeat (period - hi - 1) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      bit exp_h, exp_m;
      exp_h = in_win(acc_valid, la, LAT, OW, cyc) || in_win(prev_valid, la_prev, LAT, OW, cyc);
      exp_m = !(in_win(acc_valid, la, LAT + 1, MW, cyc) || in_win(prev_valid, la_prev, LAT + 1, MW, cyc));
      chk(hsync_out === exp_h, "R2,R3,R5 hsync_out level", int'(hsync_out), int'(exp_h));
      chk(mask_open === exp_m, "R4 mask_open level", int'(mask_open), int'(exp_m));
      if (hsync_out && !h_last) begin
        n_rise++;
        if (pal_on && have_rise)
          chk(cyc - last_rise == LINE, "R8 line interval", cyc - last_rise, LINE);
        last_rise = cyc;
        have_rise = 1'b1;
      end
      h_last = hsync_out;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'd4064));
    idle(5);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(hsync_out === 1'b0, "R1 hsync_out after reset", int'(hsync_out), 0);
    chk(mask_open === 1'b1, "R1 mask_open after reset", int'(mask_open), 1);
    mon_en = 1'b1;
    idle(20);

    // R1: first pulse passes
    send(47, 1000);
    chk(n_rise == 1, "R1 first pulse accepted", n_rise, 1);

    // R8: normal, broad, equalizing, normal
    pal_on = 1'b1;
    have_rise = 1'b0;
    base = n_rise;
    repeat (6) send(47, LINE);
    repeat (6) send(23, HALF);
    repeat (6) send(273, HALF);
    repeat (6) send(23, HALF);
    repeat (6) send(47, LINE);
    pal_on = 1'b0;
    idle(400);
    chk(n_rise - base == 21, "R8 pulses in frame sequence", n_rise - base, 21);

    // R5: boundary of hold-off
    base = n_rise;
    send(20, MW + 1);
    send(20, 1000);
    chk(n_rise - base == 1, "R5 rise at MASK+1 dropped", n_rise - base, 1);
    send(20, MW + 2);
    send(20, 1000);
    chk(n_rise - base == 3, "R5 rise at MASK+2 accepted", n_rise - base, 3);
    base = n_rise;
    send(20, MW + 2 - 40);
    send(20, 1000);
    chk(n_rise - base == 1, "R6 mask reopens inside stretch, dropped", n_rise - base, 1);

    // R7: retrigger chain longer than the mask window
    base = n_rise;
    repeat (12) send(10, 40);
    idle(1000);
    chk(n_rise - base == 1, "R7 retriggered chain single pulse", n_rise - base, 1);
    base = n_rise;
    send(10, SW + 1);
    send(10, 1000);
    chk(n_rise - base == 1, "R7 rise at STRETCH+1 blocked by mask", n_rise - base, 1);

    // Random spacing and widths
    for (int i = 0; i < 60; i++) begin
      int per, hi;
      per = 90 + int'($urandom % 700);
      hi  = 3 + int'($urandom % (per / 2));
      send(hi, per);
    end
    idle(1200);
    chk(n_rise == n_acc, "R5 total accepted pulses", n_rise, n_acc);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule